// File: doc/BRIEF.md
# Triple-Copy Self-Repairing RAM

This block is a storage wrapper that keeps every word three times, in three dual-port RAM banks. A single user port reads and writes the store. A write updates all three banks at once. A read returns the bitwise two-out-of-three majority of the three stored words. Because of the vote, an upset in one bank never reaches the user.

The second port of every bank belongs to a background sweeper that never stops. For each address it spends one cycle reading all three banks. In the next cycle it votes the three words and writes the voted word back into all three banks. It then moves to the next address, and after the last address it starts again at zero. Single-bank upsets are therefore cleared within one full sweep and do not build up in long-lived data.

A collision guard suppresses the write-back when the user writes the same address during either sweep cycle for that address, so fresh user data is never replaced with a stale vote. A saturating counter records every write-back that found a bank disagreeing with the vote.

Top module: `tmr_scrub_ram`

## Requirements
- R1: After reset, usrRdata is 0 and repairCount is 0.
- R2: A user read (usrEn=1, usrWe=0) presents the word last written to that address on usrRdata one clock edge later.
- R3: The read result is the per-bit majority of the three banks. A read is correct when one bank holds a wrong word. It is also correct when two banks are wrong in disjoint bit positions.
- R4: The sweeper rewrites every bank with the voted word. After one full sweep (2·2^ADDR_W cycles), a bank that was corrupted earlier holds the correct word again.
- R5: The sweep visits addresses 0, 1, …, 2^ADDR_W−1, then 0 again, and spends two cycles on each address. Counting active clock edges after reset from 0, edge k reads address (k/2) mod 2^ADDR_W when k is even, and edge k+1 writes that address back.
- R6: A user write to the address that the sweeper reads at the same edge is kept. The write-back one edge later is dropped.
- R7: A user write to the address that the sweeper writes back at the same edge is kept. The write-back is dropped.
- R8: repairCount rises by exactly 1 for each write-back whose three read words were not all equal. It never decreases before reset and saturates at its maximum. It does not change while all banks agree.
- R9: usrRdata changes only on a user read. User writes and sweep activity leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| usrEn | input | 1 | User access strobe |
| usrWe | input | 1 | 1 = write, 0 = read (when usrEn=1) |
| usrAddr | input | ADDR_W | User word address |
| usrWdata | input | DATA_W | User write word |
| usrRdata | output | DATA_W | Voted read word, one edge after the read |
| repairCount | output | CNT_W | Saturating count of write-backs that found a disagreeing bank |

## Verification
The properties assume that rst_n is held low for at least one edge before use, and that usrAddr and usrEn are known whenever rst_n is high. The guard checks compare the user address with the sweep address only while a write is requested. The bench drives every input at falling edges and keeps usrEn low between accesses. It places injected upsets half a sweep away from the sweeper's current address, so no upset lands between the read and the write-back of its own word. Collision cases are placed on exactly the edges given in R5.

// File: rtl/tmr_scrub_pkg.sv
package tmr_scrub_pkg;

  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } sweepPhase_e;

  // strobes from the sweep control to the datapath
  typedef struct packed {
    logic rdEn;   // read all three banks at sweepAddr
    logic wbEn;   // write voted word back to all three banks
  } scrubCtl_t;

endpackage

// File: rtl/tmr_ram_bank.sv
module tmr_ram_bank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aEn,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aQ,
  input  logic              bEn,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage: port B is written after port A, the guard upstream keeps them apart
  always_ff @(posedge clk) begin
    if (aEn && aWe) mem[aAddr] <= aWdata;
    if (bEn && bWe) mem[bAddr] <= bWdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aQ <= '0;
      bQ <= '0;
    end else begin
      if (aEn && !aWe) aQ <= mem[aAddr];
      if (bEn && !bWe) bQ <= mem[bAddr];
    end
  end

endmodule

// File: rtl/tmr_scrub_ctrl.sv
module tmr_scrub_ctrl
  import tmr_scrub_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usrEn,
  input  logic              usrWe,
  input  logic [ADDR_W-1:0] usrAddr,
  output logic [ADDR_W-1:0] sweepAddr,
  output logic              writePhase,
  output scrubCtl_t         ctl
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((1 << ADDR_W) - 1);

  sweepPhase_e phase;
  logic        hitNow;
  logic        hitHeld;

  assign hitNow     = usrEn && usrWe && (usrAddr == sweepAddr);
  assign writePhase = (phase == PH_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_READ;
      sweepAddr <= '0;
      hitHeld   <= 1'b0;
    end else if (phase == PH_READ) begin
      phase   <= PH_WRITE;
      hitHeld <= hitNow;
    end else begin
      phase     <= PH_READ;
      hitHeld   <= 1'b0;
      sweepAddr <= (sweepAddr == LAST_ADDR) ? '0 : sweepAddr + 1'b1;
    end
  end

  always_comb begin
    ctl.rdEn = (phase == PH_READ);
    ctl.wbEn = (phase == PH_WRITE) && !hitHeld && !hitNow;
  end

endmodule

// File: rtl/tmr_scrub_dp.sv
module tmr_scrub_dp
  import tmr_scrub_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usrEn,
  input  logic              usrWe,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [DATA_W-1:0] usrWdata,
  input  logic [ADDR_W-1:0] sweepAddr,
  input  scrubCtl_t         ctl,
  output logic [DATA_W-1:0] usrRdata,
  output logic [CNT_W-1:0]  repairCount
);
  localparam int COPIES = 3;

  logic [DATA_W-1:0] qA [COPIES];
  logic [DATA_W-1:0] qB [COPIES];
  logic [DATA_W-1:0] sweepVote;
  logic              bEn;
  logic              mismatch;

  assign bEn = ctl.rdEn || ctl.wbEn;

  for (genvar c = 0; c < COPIES; c++) begin : gCopy
    tmr_ram_bank #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
    ) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .aEn   (usrEn),
      .aWe   (usrWe),
      .aAddr (usrAddr),
      .aWdata(usrWdata),
      .aQ    (qA[c]),
      .bEn   (bEn),
      .bWe   (ctl.wbEn),
      .bAddr (sweepAddr),
      .bWdata(sweepVote),
      .bQ    (qB[c])
    );
  end

  // bitwise two-out-of-three vote on both sides
  assign usrRdata  = (qA[0] & qA[1]) | (qA[0] & qA[2]) | (qA[1] & qA[2]);
  assign sweepVote = (qB[0] & qB[1]) | (qB[0] & qB[2]) | (qB[1] & qB[2]);

  assign mismatch = (qB[0] != sweepVote) || (qB[1] != sweepVote) || (qB[2] != sweepVote);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      repairCount <= '0;
    end else if (ctl.wbEn && mismatch && (repairCount != {CNT_W{1'b1}})) begin
      repairCount <= repairCount + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_scrub_ram.sv
module tmr_scrub_ram
  import tmr_scrub_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usrEn,
  input  logic              usrWe,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [DATA_W-1:0] usrWdata,
  output logic [DATA_W-1:0] usrRdata,
  output logic [CNT_W-1:0]  repairCount
);
  logic [ADDR_W-1:0] sweepAddr;
  logic              writePhase;
  scrubCtl_t         ctl;

  tmr_scrub_ctrl #(
    .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .usrEn     (usrEn),
    .usrWe     (usrWe),
    .usrAddr   (usrAddr),
    .sweepAddr (sweepAddr),
    .writePhase(writePhase),
    .ctl       (ctl)
  );

  tmr_scrub_dp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .usrEn      (usrEn),
    .usrWe      (usrWe),
    .usrAddr    (usrAddr),
    .usrWdata   (usrWdata),
    .sweepAddr  (sweepAddr),
    .ctl        (ctl),
    .usrRdata   (usrRdata),
    .repairCount(repairCount)
  );

endmodule

// File: rtl/tmr_scrub_ram_chk.sv
module tmr_scrub_ram_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              usrEn,
  input logic              usrWe,
  input logic [ADDR_W-1:0] usrAddr,
  input logic [CNT_W-1:0]  repairCount,
  input logic [ADDR_W-1:0] sweepAddr,
  input logic              writePhase,
  input logic              rdFire,
  input logic              wbFire
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((1 << ADDR_W) - 1);

  logic userHit;
  assign userHit = usrEn && usrWe && (usrAddr == sweepAddr);

  p_phase_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdFire |=> !rdFire);

  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !writePhase |=> writePhase);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (writePhase && sweepAddr == LAST_ADDR) |=> (sweepAddr == '0));

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (writePhase && sweepAddr != LAST_ADDR) |=> (sweepAddr == $past(sweepAddr) + 1'b1));

  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !writePhase |=> $stable(sweepAddr));

  p_guard_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!writePhase && userHit) |=> !wbFire);

  p_guard_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (writePhase && userHit) |-> !wbFire);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (repairCount != {CNT_W{1'b1}}) |=>
      ((repairCount == $past(repairCount)) || (repairCount == $past(repairCount) + 1'b1)));

  p_count_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (repairCount == {CNT_W{1'b1}}) |=> $stable(repairCount));

  p_count_only_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wbFire |=> $stable(repairCount));

endmodule

bind tmr_scrub_ram tmr_scrub_ram_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .usrEn      (usrEn),
  .usrWe      (usrWe),
  .usrAddr    (usrAddr),
  .repairCount(repairCount),
  .sweepAddr  (sweepAddr),
  .writePhase (writePhase),
  .rdFire     (ctl.rdEn),
  .wbFire     (ctl.wbEn)
);

// File: tb/test_tmr_scrub_ram.sv
module test_tmr_scrub_ram;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int CW    = 8;
  localparam int SWEEP = 2 * (1 << AW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          usrEn = 1'b0;
  logic          usrWe = 1'b0;
  logic [AW-1:0] usrAddr = '0;
  logic [DW-1:0] usrWdata = '0;
  logic [DW-1:0] usrRdata;
  logic [CW-1:0] repairCount;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;    // index of the next active edge since reset release
  int expCnt = 0;

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  tmr_scrub_ram #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) i_tmr_scrub_ram (
    .clk(clk), .rst_n(rst_n), .usrEn(usrEn), .usrWe(usrWe),
    .usrAddr(usrAddr), .usrWdata(usrWdata),
    .usrRdata(usrRdata), .repairCount(repairCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic userWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    usrEn = 1'b1; usrWe = 1'b1; usrAddr = a; usrWdata = d;
    @(negedge clk);
    usrEn = 1'b0; usrWe = 1'b0;
  endtask

  task automatic userRead(input logic [AW-1:0] a, output logic [DW-1:0] q);
    usrEn = 1'b1; usrWe = 1'b0; usrAddr = a;
    @(negedge clk);
    usrEn = 1'b0;
    q = usrRdata;
  endtask

  task automatic alignTo(input int m);
    @(negedge clk);
    while ((cyc % SWEEP) != m) @(negedge clk);
  endtask

  // next edge lies half a sweep away from the read of address a
  task automatic alignSafe(input int a);
    alignTo((2 * a + SWEEP / 2) % SWEEP);
  endtask

  task automatic corrupt(input int c, input logic [AW-1:0] a, input logic [DW-1:0] v);
    case (c)
      0: i_tmr_scrub_ram.i_dp.gCopy[0].i_bank.mem[a] <= v;
      1: i_tmr_scrub_ram.i_dp.gCopy[1].i_bank.mem[a] <= v;
      default: i_tmr_scrub_ram.i_dp.gCopy[2].i_bank.mem[a] <= v;
    endcase
  endtask

  task automatic waitSweep();
    repeat (SWEEP + 8) @(negedge clk);
  endtask

  task automatic t_reset();
    check(usrRdata == '0, "R1 rdata", usrRdata, 0);
    check(repairCount == '0, "R1 count", repairCount, 0);
  endtask

  task automatic t_basic();
    logic [DW-1:0] q;
    for (int a = 0; a < (1 << AW); a++) userWrite(AW'(a), DW'(a * 37 + 11));
    for (int a = 0; a < (1 << AW); a += 5) begin
      userRead(AW'(a), q);
      check(q == DW'(a * 37 + 11), "R2 readback", q, a * 37 + 11);
    end
    waitSweep();
    check(repairCount == CW'(expCnt), "R8 clean sweep", repairCount, expCnt);
  endtask

  task automatic t_vote();
    logic [DW-1:0] q;
    userWrite(4'd3, 8'hA5);
    alignSafe(3);
    corrupt(2, 4'd3, 8'h5A);
    @(negedge clk);
    userRead(4'd3, q);
    check(q == 8'hA5, "R3 one bank wrong", q, 8'hA5);
    waitSweep(); expCnt++;
    check(repairCount == CW'(expCnt), "R8 count one bank", repairCount, expCnt);
    alignSafe(3);
    corrupt(0, 4'd3, 8'hA5 ^ 8'h0F);
    corrupt(1, 4'd3, 8'hA5 ^ 8'hF0);
    @(negedge clk);
    userRead(4'd3, q);
    check(q == 8'hA5, "R3 disjoint bits", q, 8'hA5);
    waitSweep(); expCnt++;
    check(repairCount == CW'(expCnt), "R8 count two banks", repairCount, expCnt);
  endtask

  task automatic t_repair();
    logic [DW-1:0] q;
    userWrite(4'd5, 8'h3C);
    alignSafe(5);
    corrupt(1, 4'd5, 8'hC3);
    waitSweep(); expCnt++;
    alignSafe(5);
    corrupt(2, 4'd5, 8'hC3);
    @(negedge clk);
    userRead(4'd5, q);
    check(q == 8'h3C, "R4 bank repaired", q, 8'h3C);
    waitSweep(); expCnt++;
    check(repairCount == CW'(expCnt), "R4 repair count", repairCount, expCnt);
  endtask

  task automatic t_order();
    int k;
    userWrite(4'd9, 8'h66);
    alignSafe(9);
    k = cyc;
    corrupt(0, 4'd9, 8'h67);
    while (cyc != k + SWEEP / 2 + 1) @(negedge clk);
    check(repairCount == CW'(expCnt), "R5 before write-back", repairCount, expCnt);
    @(negedge clk); expCnt++;
    check(repairCount == CW'(expCnt), "R5 at write-back", repairCount, expCnt);
  endtask

  task automatic t_multi();
    alignSafe(12);
    corrupt(1, 4'd12, 8'hFF);
    corrupt(2, 4'd13, 8'h00);
    waitSweep(); expCnt += 2;
    check(repairCount == CW'(expCnt), "R8 two addresses", repairCount, expCnt);
  endtask

  task automatic t_collide_read();
    logic [DW-1:0] q;
    userWrite(4'd7, 8'h11);
    alignTo(14);
    userWrite(4'd7, 8'h22);
    repeat (3) @(negedge clk);
    userRead(4'd7, q);
    check(q == 8'h22, "R6 write at sweep read", q, 8'h22);
  endtask

  task automatic t_collide_wb();
    logic [DW-1:0] q;
    userWrite(4'd10, 8'h44);
    alignTo(21);
    userWrite(4'd10, 8'h99);
    repeat (3) @(negedge clk);
    userRead(4'd10, q);
    check(q == 8'h99, "R7 write at write-back", q, 8'h99);
    check(repairCount == CW'(expCnt), "R7 no false count", repairCount, expCnt);
  endtask

  task automatic t_hold();
    logic [DW-1:0] q;
    userRead(4'd2, q);
    userWrite(4'd2, 8'hEE);
    repeat (SWEEP) @(negedge clk);
    check(usrRdata == q, "R9 hold over write and sweep", usrRdata, q);
    userRead(4'd2, q);
    check(q == 8'hEE, "R9 new read", q, 8'hEE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_vote();
    t_repair();
    t_order();
    t_multi();
    t_collide_read();
    t_collide_wb();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule